// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is a file of chipset configuration bytes. The host reaches it through two byte-wide I/O locations. A write to the selector port latches a register number. A read or write at the access port then reaches the byte that number picks, but only if the number falls inside a window set by parameters. Each access at the access port returns the selector to zero. Because of that, software must write the selector again before each data transfer.

The block also holds two general-purpose scratch bytes at their own I/O addresses. All stored configuration bytes go out on a flat bus for neighbouring decoders. A one-clock written strobe per register tells those decoders when to recompute. One register in the file has write-one-to-clear behaviour, so it can serve as a status byte.

Top module: `cfg_index_port`

## Requirements
- R1: A write to I/O address 0x0022 latches the byte as the selector. A following access at 0x0023 reaches register slot (selector − WIN_BASE). Slot k appears on cfg_regs bits [8k+7:8k].
- R2: Any read or write at 0x0023 returns the selector to zero on the same clock edge. A second access with no new selector write uses selector 0x00, which lies outside the default window.
- R3: An access at 0x0023 counts only when WIN_BASE ≤ selector ≤ WIN_BASE+LAST_OFS. The defaults are 0x50 and 0x76, so the window runs from 0x50 to 0xC6 inclusive. Outside the window a write changes no register and a read returns 0xFF.
- R4: The slot at offset W1C_OFS (default 0x19, selector 0x69) is write-one-to-clear. Each 1 bit written clears the matching stored bit, and each 0 bit leaves it unchanged.
- R5: Every other in-window slot takes the written byte unchanged.
- R6: Scratch bytes at 0x00E1 and 0x00E2 are independently readable and writable, and both reset to 0xFF.
- R7: Read data is registered. io_rdata shows the value one clock edge after the edge that samples io_rd, and it holds until the next read. A read of any other address, including 0x0022, returns 0xFF.
- R8: Under synchronous reset (rst high) the selector is zero and slot k loads RST_IMAGE[8k+7:8k].
- R9: Each accepted write to slot k, W1C slot included, raises cfg_wr_pulse[k] for exactly the one cycle after the write edge. A rejected write raises no strobe, and at most one strobe bit is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, sampled on clk rising edge |
| io_rd | input | 1 | Read strobe, sampled on clk rising edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| cfg_regs | output | 8*(LAST_OFS+1) | All configuration slots, slot k at [8k+7:8k] |
| cfg_wr_pulse | output | LAST_OFS+1 | One-cycle written strobe per slot |

## Verification
The hardest case is a data access made with a stale selector. After any data-port cycle the selector silently returns to zero, and this state shows at the ports only as a read returning 0xFF or a write that changes nothing. The stimulus runs two access-port cycles back to back with no selector write between them. It checks the second read for 0xFF, and after the second write it compares the whole cfg_regs bus with a snapshot taken before. The window edges at 0x4F, 0x50, 0xC6 and 0xC7, and the clear-only status byte, each get their own directed sequences.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_INDEX,
        TGT_DATA,
        TGT_SCR0,
        TGT_SCR1
    } io_tgt_e;

    typedef struct packed {
        logic       wr;
        logic       rd;
        io_tgt_e    tgt;
        logic [7:0] wdata;
    } io_req_t;

    localparam logic [7:0] FLOAT_BYTE = 8'hFF;

    function automatic io_tgt_e decode_addr(
        input logic [15:0] a,
        input logic [15:0] idx_a,
        input logic [15:0] dat_a,
        input logic [15:0] s0_a,
        input logic [15:0] s1_a
    );
        if (a == idx_a)      return TGT_INDEX;
        else if (a == dat_a) return TGT_DATA;
        else if (a == s0_a)  return TGT_SCR0;
        else if (a == s1_a)  return TGT_SCR1;
        else                 return TGT_NONE;
    endfunction

endpackage

// File: rtl/cfg_bus_decode.sv
module cfg_bus_decode
    import cfgport_pkg::*;
#(
    parameter logic [15:0] IDX_ADDR  = 16'h0022,
    parameter logic [15:0] DATA_ADDR = 16'h0023,
    parameter logic [15:0] SCR0_ADDR = 16'h00E1,
    parameter logic [15:0] SCR1_ADDR = 16'h00E2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [7:0]  io_wdata,
    input  logic        data_hit,
    input  logic [7:0]  data_rd_val,
    output io_req_t     req,
    output logic [7:0]  io_rdata
);
    logic [7:0] scr_q [2];
    logic [7:0] rd_next;

    always_comb begin
        req.wr    = io_wr;
        req.rd    = io_rd;
        req.wdata = io_wdata;
        req.tgt   = decode_addr(io_addr, IDX_ADDR, DATA_ADDR, SCR0_ADDR, SCR1_ADDR);
    end

    always_comb begin
        unique case (req.tgt)
            TGT_DATA: rd_next = data_hit ? data_rd_val : FLOAT_BYTE;
            TGT_SCR0: rd_next = scr_q[0];
            TGT_SCR1: rd_next = scr_q[1];
            default:  rd_next = FLOAT_BYTE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scr_q[0] <= FLOAT_BYTE;
            scr_q[1] <= FLOAT_BYTE;
            io_rdata <= FLOAT_BYTE;
        end else begin
            if (req.wr && req.tgt == TGT_SCR0) scr_q[0] <= req.wdata;
            if (req.wr && req.tgt == TGT_SCR1) scr_q[1] <= req.wdata;
            if (req.rd) io_rdata <= rd_next;
        end
    end

    AST_UNMAPPED_FLOAT: assert property (@(posedge clk) disable iff (rst)
        (io_rd && req.tgt == TGT_NONE) |=> (io_rdata == 8'hFF)) else $error("unmapped read"); // R7

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !io_rd |=> $stable(io_rdata)) else $error("rdata moved"); // R7

endmodule

// File: rtl/cfg_index_reg.sv
module cfg_index_reg
    import cfgport_pkg::*;
#(
    parameter logic [7:0] WIN_BASE = 8'h50,
    parameter int         LAST_OFS = 8'h76,
    parameter int         OFSW     = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  io_req_t         req,
    output logic            in_win,
    output logic [OFSW-1:0] ofs
);
    localparam logic [7:0] WIN_LAST = WIN_BASE + 8'(LAST_OFS);

    logic [7:0] idx_q;
    logic [7:0] rel;
    logic       data_cycle;

    assign data_cycle = (req.tgt == TGT_DATA) && (req.wr || req.rd);
    assign rel        = idx_q - WIN_BASE;
    assign in_win     = (idx_q >= WIN_BASE) && (idx_q <= WIN_LAST);
    assign ofs        = rel[OFSW-1:0];

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= 8'h00;
        else if (req.wr && req.tgt == TGT_INDEX)
            idx_q <= req.wdata;
        else if (data_cycle)
            idx_q <= 8'h00;
    end

    AST_IDX_AUTOCLEAR: assert property (@(posedge clk) disable iff (rst)
        data_cycle |=> (idx_q == 8'h00)) else $error("selector kept"); // R2

    AST_IDX_LATCH: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.tgt == TGT_INDEX) |=> (idx_q == $past(req.wdata))) else $error("selector not latched"); // R1

endmodule

// File: rtl/cfg_reg_array.sv
module cfg_reg_array #(
    parameter int                      NREG     = 119,
    parameter int                      OFSW     = 7,
    parameter int                      W1C_OFS  = 8'h19,
    parameter logic [NREG*8-1:0]       RST_IMAGE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFSW-1:0]   wr_ofs,
    input  logic [7:0]        wdata,
    input  logic [OFSW-1:0]   rd_ofs,
    output logic [7:0]        rd_val,
    output logic [NREG*8-1:0] regs_flat,
    output logic [NREG-1:0]   wr_pulse
);
    logic [7:0] slot_q [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_ofs == OFSW'(k));

        if (k == W1C_OFS) begin : g_w1c
            always_ff @(posedge clk) begin
                if (rst)      slot_q[k] <= RST_IMAGE[8*k +: 8];
                else if (hit) slot_q[k] <= slot_q[k] & ~wdata;
            end
            AST_W1C_NO_SET: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> ((slot_q[k] & ~$past(slot_q[k])) == 8'h00)) else $error("w1c bit set"); // R4
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)      slot_q[k] <= RST_IMAGE[8*k +: 8];
                else if (hit) slot_q[k] <= wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) wr_pulse[k] <= 1'b0;
            else     wr_pulse[k] <= hit;
        end

        assign regs_flat[8*k +: 8] = slot_q[k];
    end

    assign rd_val = (int'(rd_ofs) < NREG) ? slot_q[rd_ofs] : 8'hFF;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_pulse)) else $error("multiple strobes"); // R9

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
    import cfgport_pkg::*;
#(
    parameter logic [7:0]  WIN_BASE  = 8'h50,
    parameter int          LAST_OFS  = 8'h76,
    parameter int          W1C_OFS   = 8'h19,
    parameter logic [(LAST_OFS+1)*8-1:0] RST_IMAGE = '0,
    parameter logic [15:0] IDX_ADDR  = 16'h0022,
    parameter logic [15:0] DATA_ADDR = 16'h0023,
    parameter logic [15:0] SCR0_ADDR = 16'h00E1,
    parameter logic [15:0] SCR1_ADDR = 16'h00E2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [15:0]                io_addr,
    input  logic                       io_wr,
    input  logic                       io_rd,
    input  logic [7:0]                 io_wdata,
    output logic [7:0]                 io_rdata,
    output logic [(LAST_OFS+1)*8-1:0]  cfg_regs,
    output logic [LAST_OFS:0]          cfg_wr_pulse
);
    localparam int NREG = LAST_OFS + 1;
    localparam int OFSW = (NREG > 1) ? $clog2(NREG) : 1;

    io_req_t         req;
    logic            in_win;
    logic [OFSW-1:0] ofs;
    logic [7:0]      rd_val;
    logic            data_wr_ok;

    cfg_bus_decode #(
        .IDX_ADDR (IDX_ADDR),
        .DATA_ADDR(DATA_ADDR),
        .SCR0_ADDR(SCR0_ADDR),
        .SCR1_ADDR(SCR1_ADDR)
    ) u_decode (
        .clk        (clk),
        .rst        (rst),
        .io_addr    (io_addr),
        .io_wr      (io_wr),
        .io_rd      (io_rd),
        .io_wdata   (io_wdata),
        .data_hit   (in_win),
        .data_rd_val(rd_val),
        .req        (req),
        .io_rdata   (io_rdata)
    );

    cfg_index_reg #(
        .WIN_BASE(WIN_BASE),
        .LAST_OFS(LAST_OFS),
        .OFSW    (OFSW)
    ) u_index (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .in_win(in_win),
        .ofs   (ofs)
    );

    assign data_wr_ok = req.wr && (req.tgt == TGT_DATA) && in_win;

    cfg_reg_array #(
        .NREG     (NREG),
        .OFSW     (OFSW),
        .W1C_OFS  (W1C_OFS),
        .RST_IMAGE(RST_IMAGE)
    ) u_array (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (data_wr_ok),
        .wr_ofs   (ofs),
        .wdata    (req.wdata),
        .rd_ofs   (ofs),
        .rd_val   (rd_val),
        .regs_flat(cfg_regs),
        .wr_pulse (cfg_wr_pulse)
    );

    AST_OUTWIN_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (io_wr && req.tgt == TGT_DATA && !in_win) |=> $stable(cfg_regs)) else $error("rejected write landed"); // R3

    AST_OUTWIN_READ_FF: assert property (@(posedge clk) disable iff (rst)
        (io_rd && !io_wr && req.tgt == TGT_DATA && !in_win) |=> (io_rdata == 8'hFF)) else $error("rejected read data"); // R3

    AST_NO_STROBE_REJECT: assert property (@(posedge clk) disable iff (rst)
        !data_wr_ok |=> (cfg_wr_pulse == '0)) else $error("stray strobe"); // R9

endmodule

// File: tb/test_cfg_index_port.sv
module test_cfg_index_port;
    localparam int NREG = 119;

    function automatic logic [NREG*8-1:0] make_image();
        logic [NREG*8-1:0] v;
        for (int k = 0; k < NREG; k++) v[8*k +: 8] = 8'(k) ^ 8'h3C;
        return v;
    endfunction
    localparam logic [NREG*8-1:0] IMG = make_image();

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [15:0]       io_addr = '0;
    logic              io_wr = 1'b0;
    logic              io_rd = 1'b0;
    logic [7:0]        io_wdata = '0;
    logic [7:0]        io_rdata;
    logic [NREG*8-1:0] cfg_regs;
    logic [NREG-1:0]   cfg_wr_pulse;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cfg_index_port #(.RST_IMAGE(IMG)) i_cfg_index_port (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_regs(cfg_regs),
        .cfg_wr_pulse(cfg_wr_pulse)
    );

    task automatic check(input string req, input logic [NREG*8-1:0] act, input logic [NREG*8-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk); io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk); io_addr = a; io_rd = 1'b1;
        @(negedge clk); io_rd = 1'b0; d = io_rdata;
    endtask

    // op: 0 write, 1 read and compare; {op, addr, data-or-expected}
    localparam int NV = 24;
    localparam logic [17:0] VEC [NV] = '{
        {2'd0, 8'h22, 8'h50}, {2'd0, 8'h23, 8'h11},          // R1 R5 lowest slot
        {2'd0, 8'h22, 8'h50}, {2'd1, 8'h23, 8'h11},
        {2'd1, 8'h23, 8'hFF},                                // R2 stale selector
        {2'd0, 8'h22, 8'hC6}, {2'd0, 8'h23, 8'h77},          // R3 top edge
        {2'd0, 8'h22, 8'hC6}, {2'd1, 8'h23, 8'h77},
        {2'd0, 8'h22, 8'hC7}, {2'd1, 8'h23, 8'hFF},          // R3 above
        {2'd0, 8'h22, 8'h4F}, {2'd1, 8'h23, 8'hFF},          // R3 below
        {2'd0, 8'h22, 8'h69}, {2'd0, 8'h23, 8'h05},          // R4 0x25 -> 0x20
        {2'd0, 8'h22, 8'h69}, {2'd1, 8'h23, 8'h20},
        {2'd0, 8'hE1, 8'h12}, {2'd1, 8'hE1, 8'h12},          // R6
        {2'd1, 8'hE2, 8'hFF},
        {2'd1, 8'h10, 8'hFF}, {2'd1, 8'h22, 8'hFF},          // R7 unmapped, selector port
        {2'd0, 8'h22, 8'h55}, {2'd1, 8'h23, 8'h05 ^ 8'h3C}   // R8 reset image via port
    };

    initial begin
        logic [7:0] d;
        logic [NREG*8-1:0] snap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8 reset state
        check("R8 image", cfg_regs, IMG);
        check("R9 idle strobe", {{(NREG*8-NREG){1'b0}}, cfg_wr_pulse}, '0);
        io_read(16'h0023, d); check("R8 selector zero", {{(NREG*8-8){1'b0}}, d}, {{(NREG*8-8){1'b0}}, 8'hFF});
        io_read(16'h00E1, d); check("R6 scratch0 reset", {{(NREG*8-8){1'b0}}, d}, {{(NREG*8-8){1'b0}}, 8'hFF});

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][17:16] == 2'd0) io_write({8'h00, VEC[i][15:8]}, VEC[i][7:0]);
            else begin
                io_read({8'h00, VEC[i][15:8]}, d);
                check($sformatf("R1/R2/R3/R4/R6/R7 vec %0d", i), {{(NREG*8-8){1'b0}}, d},
                      {{(NREG*8-8){1'b0}}, VEC[i][7:0]});
            end
        end

        // R5 value on cfg_regs slot 0 and slot 0x76
        check("R5 slot0", {{(NREG*8-8){1'b0}}, cfg_regs[7:0]}, {{(NREG*8-8){1'b0}}, 8'h11});
        check("R5 slot76", {{(NREG*8-8){1'b0}}, cfg_regs[8*118 +: 8]}, {{(NREG*8-8){1'b0}}, 8'h77});

        // R2 / R3 stale-selector write changes nothing
        io_write(16'h0022, 8'h60);
        io_write(16'h0023, 8'hAA);
        snap = cfg_regs;
        io_write(16'h0023, 8'h99);
        check("R2 stale write ignored", cfg_regs, snap);
        io_write(16'h0022, 8'hC7);
        io_write(16'h0023, 8'h5A);
        check("R3 outwin write ignored", cfg_regs, snap);
        check("R5 slot10", {{(NREG*8-8){1'b0}}, cfg_regs[8*16 +: 8]}, {{(NREG*8-8){1'b0}}, 8'hAA});

        // R9 strobe timing
        io_write(16'h0022, 8'h53);
        @(negedge clk); io_addr = 16'h0023; io_wdata = 8'h44; io_wr = 1'b1;
        @(negedge clk); io_wr = 1'b0;
        check("R9 strobe high", {{(NREG*8-NREG){1'b0}}, cfg_wr_pulse}, {{(NREG*8-NREG){1'b0}}, NREG'(1) << 3});
        @(negedge clk);
        check("R9 strobe gone", {{(NREG*8-NREG){1'b0}}, cfg_wr_pulse}, '0);
        // R9 rejected write: no strobe
        @(negedge clk); io_addr = 16'h0023; io_wdata = 8'h01; io_wr = 1'b1;
        @(negedge clk); io_wr = 1'b0;
        check("R9 no strobe on reject", {{(NREG*8-NREG){1'b0}}, cfg_wr_pulse}, '0);

        // R4 zero bits keep, ones clear
        io_write(16'h0022, 8'h69);
        io_write(16'h0023, 8'h00);
        check("R4 zero keeps", {{(NREG*8-8){1'b0}}, cfg_regs[8*25 +: 8]}, {{(NREG*8-8){1'b0}}, 8'h20});
        io_write(16'h0022, 8'h69);
        io_write(16'h0023, 8'hFF);
        check("R4 all clear", {{(NREG*8-8){1'b0}}, cfg_regs[8*25 +: 8]}, '0);

        // R7 rdata holds without a read
        io_write(16'h00E2, 8'h3D);
        io_read(16'h00E2, d);
        repeat (2) @(negedge clk);
        check("R7 rdata hold", {{(NREG*8-8){1'b0}}, io_rdata}, {{(NREG*8-8){1'b0}}, 8'h3D});

        // R8 reset again restores image and scratch
        rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
        check("R8 reset image again", cfg_regs, IMG);
        io_read(16'h00E2, d); check("R6 scratch1 reset", {{(NREG*8-8){1'b0}}, d}, {{(NREG*8-8){1'b0}}, 8'hFF});

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule